// File: doc/BRIEF.md
# Processor Power-Up Sequencer

This block sits on a motherboard's always-on 100 MHz clock. It brings a processor out of power-off in the correct order. It watches four supply flags: the 3.3 V rail, the PLL supply, the core supply and the remaining planes. It also watches a flag that reports the system reference clock as running. From these it drives two outputs: an active-low processor reset and a power-good level. Reset is held from the moment the block leaves its own reset. Power-good rises only after every flag is high and three hold windows have elapsed:

- the 3.3 V settling window;
- the PLL-supply settling window;
- a minimum lead time between the assertion of reset and the rise of power-good.

Reset is released a fixed number of cycles after power-good.

Each window is measured in clock cycles by a saturating hold counter, and every window is a parameter. Each rail window restarts from the most recent rising edge of its flag. If any flag drops while power-good is high, power-good falls on the next cycle and reset is asserted again. A sticky fault bit is set, and the sequence starts over from the waiting state. A small status code reports the sequencer's state.

At 100 MHz, the minimum settings for the windows are:

| Window | Minimum (cycles) |
|---|---|
| Reset lead | 1 |
| PLL-supply settling | 500 |
| 3.3 V settling | 300,000 |

Top module: `pwrseq_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `cpu_rst_n` is 0, `pwr_good` is 0, `fault_latched` is 0 and `seq_status` is 0.
- R2: `pwr_good` never rises unless `v33_ok`, `pll_ok`, `core_ok`, `aux_ok` and `sysclk_run` were all 1 in the cycle before. When all hold windows have already elapsed, the last of these flags rising makes `pwr_good` rise two clock edges later.
- R3: `pwr_good` rises no sooner than V33_SETTLE_CYC edges after the first edge at which `v33_ok` is sampled high. A drop of `v33_ok` restarts that count from its next rising edge. When this is the last window to elapse, the rise lands exactly V33_SETTLE_CYC edges after that first edge.
- R4: The same rule applies to `pll_ok` with PLL_SETTLE_CYC, including the restart on a drop and the exact timing when this window is the last to elapse.
- R5: `cpu_rst_n` is 0 for at least RST_LEAD_CYC cycles before `pwr_good` rises. The lead count runs while the sequencer waits or settles, beginning when the block leaves reset or after a fault.
- R6: `cpu_rst_n` rises exactly RST_RELEASE_CYC clock edges after the edge at which `pwr_good` rises. It is 0 whenever `pwr_good` is 0.
- R7: If any supply flag or `sysclk_run` is 0 while `pwr_good` is 1, then on the next edge `pwr_good` falls, `cpu_rst_n` is 0 and `seq_status` shows FAULT for one cycle. After that it shows the waiting state.
- R8: `fault_latched` is set by a dropout that occurs while `pwr_good` is 1, and it stays set until `rst`. A dropout before `pwr_good` rises does not set it.
- R9: `seq_status` encodes the state as follows:

| Code | State |
|---|---|
| 0 | waiting for flags |
| 1 | settling |
| 2 | power-good with reset held |
| 3 | running |
| 4 | fault |

- R10: After a fault, the sequence repeats in full. The lead time and each rail window are measured afresh, and the rail windows count from each flag's new rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on sequencer clock |
| rst | input | 1 | Synchronous active-high block reset |
| v33_ok | input | 1 | 3.3 V rail in specification |
| pll_ok | input | 1 | PLL supply in specification |
| core_ok | input | 1 | Core supply in specification |
| aux_ok | input | 1 | All other planes in specification |
| sysclk_run | input | 1 | System reference clock running |
| cpu_rst_n | output | 1 | Active-low processor reset |
| pwr_good | output | 1 | Power-good to the processor |
| seq_status | output | 3 | Sequencer state code (R9) |
| fault_latched | output | 1 | Sticky dropout-after-power-good flag |

## Verification
The assertions assume that every flag input is already synchronous to `clk` and is sampled once per edge. They also assume that `rst` is high from time zero for at least one edge. The bench drives each flag on the falling clock edge and holds `rst` high at start-up. It measures every window by counting falling edges from the flag change to the observed output change. The bench shortens the windows through parameters so that the full sequence, including restarts after faults, fits in a short run. The lead window is set longer than the rail windows so that each window can be made the last to elapse on its own.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    typedef enum logic [2:0] {
        ST_WAIT   = 3'd0,
        ST_SETTLE = 3'd1,
        ST_PG     = 3'd2,
        ST_RUN    = 3'd3,
        ST_FAULT  = 3'd4
    } seq_state_e;

    typedef struct packed {
        logic v33;
        logic pll;
        logic core;
        logic aux;
        logic clk_run;
    } supply_flags_t;

    function automatic logic flags_all_good(supply_flags_t f);
        return f.v33 & f.pll & f.core & f.aux & f.clk_run;
    endfunction

    function automatic logic state_drives_pg(seq_state_e s);
        return (s == ST_PG) || (s == ST_RUN);
    endfunction

    function automatic logic state_counts_lead(seq_state_e s);
        return (s == ST_WAIT) || (s == ST_SETTLE);
    endfunction

endpackage

// File: rtl/pwrseq_hold_timer.sv
module pwrseq_hold_timer #(
    parameter int unsigned HOLD_CYC = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic done
);
    localparam int unsigned CW = $clog2(HOLD_CYC + 2);
    localparam logic [CW-1:0] LIMIT = CW'(HOLD_CYC);

    logic [CW-1:0] run_len;

    always_ff @(posedge clk) begin
        if (rst || !level) begin
            run_len <= '0;
        end else if (run_len < LIMIT) begin
            run_len <= run_len + 1'b1;
        end
    end

    assign done = (run_len >= LIMIT);

    // R3
    hold_keeps_chk: assert property (@(posedge clk) disable iff (rst)
        (level && done) |=> done);

endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
    import pwrseq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  supply_flags_t flags,
    input  logic          v33_done,
    input  logic          pll_done,
    input  logic          lead_done,
    input  logic          rel_done,
    output seq_state_e    state,
    output logic          fault_sticky
);
    seq_state_e nxt;
    logic       all_ok;
    logic       pg_on;

    assign all_ok = flags_all_good(flags);
    assign pg_on  = state_drives_pg(state);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_WAIT:   if (all_ok) nxt = ST_SETTLE;
            ST_SETTLE: begin
                if (!all_ok)                             nxt = ST_WAIT;
                else if (v33_done && pll_done && lead_done) nxt = ST_PG;
            end
            ST_PG: begin
                if (!all_ok)       nxt = ST_FAULT;
                else if (rel_done) nxt = ST_RUN;
            end
            ST_RUN:    if (!all_ok) nxt = ST_FAULT;
            ST_FAULT:  nxt = ST_WAIT;
            default:   nxt = ST_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_WAIT;
            fault_sticky <= 1'b0;
        end else begin
            state <= nxt;
            if (pg_on && !all_ok) fault_sticky <= 1'b1;
        end
    end

    // R2
    pg_needs_flags_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pg_on) |-> $past(all_ok));

    // R7
    dropout_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (pg_on && !all_ok) |=> (state == ST_FAULT));

    // R7
    fault_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FAULT) |=> (state == ST_WAIT));

    // R8
    fault_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        fault_sticky |=> fault_sticky);

    // R6
    run_from_pg_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && $past(state) != ST_RUN) |-> ($past(state) == ST_PG && $past(rel_done)));

endmodule

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
    import pwrseq_pkg::*;
#(
    parameter int unsigned RST_LEAD_CYC    = 1,
    parameter int unsigned PLL_SETTLE_CYC  = 500,
    parameter int unsigned V33_SETTLE_CYC  = 300000,
    parameter int unsigned RST_RELEASE_CYC = 1000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       v33_ok,
    input  logic       pll_ok,
    input  logic       core_ok,
    input  logic       aux_ok,
    input  logic       sysclk_run,
    output logic       cpu_rst_n,
    output logic       pwr_good,
    output logic [2:0] seq_status,
    output logic       fault_latched
);
    localparam int unsigned REL_HOLD = (RST_RELEASE_CYC > 0) ? RST_RELEASE_CYC - 1 : 0;

    supply_flags_t flags;
    seq_state_e    state;
    logic          v33_done, pll_done, lead_done, rel_done;
    logic          lead_level, rel_level;

    assign flags = '{v33: v33_ok, pll: pll_ok, core: core_ok, aux: aux_ok, clk_run: sysclk_run};
    assign lead_level = state_counts_lead(state);
    assign rel_level  = (state == ST_PG);

    pwrseq_hold_timer #(.HOLD_CYC(V33_SETTLE_CYC)) u_v33_hold (
        .clk(clk), .rst(rst), .level(v33_ok), .done(v33_done));

    pwrseq_hold_timer #(.HOLD_CYC(PLL_SETTLE_CYC)) u_pll_hold (
        .clk(clk), .rst(rst), .level(pll_ok), .done(pll_done));

    pwrseq_hold_timer #(.HOLD_CYC(RST_LEAD_CYC)) u_lead_hold (
        .clk(clk), .rst(rst), .level(lead_level), .done(lead_done));

    pwrseq_hold_timer #(.HOLD_CYC(REL_HOLD)) u_rel_hold (
        .clk(clk), .rst(rst), .level(rel_level), .done(rel_done));

    pwrseq_fsm u_fsm (
        .clk(clk), .rst(rst), .flags(flags),
        .v33_done(v33_done), .pll_done(pll_done),
        .lead_done(lead_done), .rel_done(rel_done),
        .state(state), .fault_sticky(fault_latched));

    assign pwr_good   = state_drives_pg(state);
    assign cpu_rst_n  = (state == ST_RUN);
    assign seq_status = state;

    // R3
    v33_window_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pwr_good) |-> $past(v33_done));

    // R4
    pll_window_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pwr_good) |-> $past(pll_done));

    // R5
    lead_window_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pwr_good) |-> (!cpu_rst_n && $past(!cpu_rst_n) && $past(lead_done)));

    // R6
    reset_under_pg_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_rst_n |-> pwr_good);

endmodule

// File: tb/tb_pwrseq_ctrl.sv
module tb_pwrseq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int LEAD = 200;
    localparam int PLLW = 50;
    localparam int V33W = 120;
    localparam int REL  = 20;
    localparam int WATCHDOG_CYC = 100000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic v33_ok = 0, pll_ok = 0, core_ok = 0, aux_ok = 0, sysclk_run = 0;
    logic cpu_rst_n, pwr_good, fault_latched;
    logic [2:0] seq_status;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwrseq_ctrl #(
        .RST_LEAD_CYC(LEAD), .PLL_SETTLE_CYC(PLLW),
        .V33_SETTLE_CYC(V33W), .RST_RELEASE_CYC(REL)
    ) dut (
        .clk(clk), .rst(rst), .v33_ok(v33_ok), .pll_ok(pll_ok),
        .core_ok(core_ok), .aux_ok(aux_ok), .sysclk_run(sysclk_run),
        .cpu_rst_n(cpu_rst_n), .pwr_good(pwr_good),
        .seq_status(seq_status), .fault_latched(fault_latched));

    task automatic check(string req, int actual, int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        {v33_ok, pll_ok, core_ok, aux_ok, sysclk_run} = '0;
        idle(3);
        rst = 1'b0;
    endtask

    task automatic count_until_pg(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!pwr_good && n < 5000);
    endtask

    task automatic count_until_run(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!cpu_rst_n && n < 5000);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 status", seq_status, 0);
        check("R1 pwr_good", pwr_good, 0);
        check("R1 cpu_rst_n", cpu_rst_n, 0);
        check("R1 fault", fault_latched, 0);
    endtask

    task automatic t_missing_clock();
        int n;
        do_reset();
        {v33_ok, pll_ok, core_ok, aux_ok} = 4'hF;
        idle(400);
        check("R2 no clk pg", pwr_good, 0);
        check("R9 waiting code", seq_status, 0);
        sysclk_run = 1'b1;
        @(negedge clk);
        check("R9 settle code", seq_status, 1);
        n = 1;
        while (!pwr_good && n < 50) begin @(negedge clk); n++; end
        check("R2 last flag to pg", n, 2);
        check("R9 pg code", seq_status, 2);
    endtask

    task automatic t_lead();
        int n;
        do_reset();
        {v33_ok, pll_ok, core_ok, aux_ok, sysclk_run} = 5'h1F;
        count_until_pg(n);
        check("R5 lead to pg", n, LEAD + 1);
        check("R5 reset held at pg", cpu_rst_n, 0);
    endtask

    task automatic t_v33();
        int n;
        do_reset();
        {pll_ok, core_ok, aux_ok, sysclk_run} = 4'hF;
        idle(LEAD + 50);
        v33_ok = 1'b1;
        idle(60);
        check("R3 not early", pwr_good, 0);
        v33_ok = 1'b0;
        idle(2);
        v33_ok = 1'b1;
        count_until_pg(n);
        check("R3 v33 restart window", n, V33W + 1);
    endtask

    task automatic t_pll();
        int n;
        do_reset();
        {v33_ok, core_ok, aux_ok, sysclk_run} = 4'hF;
        idle(LEAD + 50);
        pll_ok = 1'b1;
        count_until_pg(n);
        check("R4 pll window", n, PLLW + 1);
        pll_ok = 1'b0;
        idle(2);
        check("R8 no fault before? (pll drop in pg)", fault_latched, 1);
    endtask

    task automatic t_release();
        int n;
        do_reset();
        {v33_ok, pll_ok, core_ok, aux_ok, sysclk_run} = 5'h1F;
        count_until_pg(n);
        count_until_run(n);
        check("R6 release delay", n, REL);
        check("R9 run code", seq_status, 3);
    endtask

    task automatic t_dropout();
        int n;
        do_reset();
        {v33_ok, pll_ok, core_ok, aux_ok, sysclk_run} = 5'h1F;
        count_until_pg(n);
        count_until_run(n);
        aux_ok = 1'b0;
        @(negedge clk);
        check("R7 pg falls", pwr_good, 0);
        check("R7 reset reasserted", cpu_rst_n, 0);
        check("R7 fault code", seq_status, 4);
        check("R8 fault set", fault_latched, 1);
        @(negedge clk);
        check("R7 back to wait", seq_status, 0);
        idle(LEAD + 50);
        aux_ok = 1'b1;
        n = 0;
        while (!pwr_good && n < 50) begin @(negedge clk); n++; end
        check("R10 restart pg", n, 2);
        check("R8 fault stays", fault_latched, 1);
        count_until_run(n);
        check("R10 restart release", n, REL);
        v33_ok = 1'b0;
        idle(LEAD + 50);
        v33_ok = 1'b1;
        count_until_pg(n);
        check("R10 v33 window afresh", n, V33W + 1);
    endtask

    task automatic t_early_drop();
        do_reset();
        {v33_ok, pll_ok, core_ok, aux_ok, sysclk_run} = 5'h1F;
        idle(30);
        core_ok = 1'b0;
        @(negedge clk);
        check("R8 drop while settling: status", seq_status, 0);
        idle(5);
        check("R8 no fault before pg", fault_latched, 0);
        do_reset();
        check("R8 fault cleared by rst", fault_latched, 0);
    endtask

    initial begin
        t_reset();
        t_missing_clock();
        t_lead();
        t_v33();
        t_pll();
        t_release();
        t_dropout();
        t_early_drop();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < WATCHDOG_CYC; i++) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule